// File: doc/BRIEF.md
# SPI Master FIFO, Status and Interrupt Front End

This block sits between a processor-facing register port and the serial shift engine of a SPI master. It keeps two word FIFOs, one carrying outbound words from software to the shift engine and one carrying inbound words from the shift engine back to software. A single level register packs both occupancy counts, so one read tells software how much room or data there is.

The block also collects transfer events into sticky status flags that software clears by writing ones. It raises two further flags when FIFO occupancy crosses programmable trigger levels. It raises two more when the shift engine pops an empty outbound FIFO or pushes into a full inbound FIFO. Each flag except the pending flag has an enable bit. The interrupt line is the OR of every enabled flag. Clock division and bit shifting are handled elsewhere.

Top module: `spi_fe_top`

## Requirements
- R1: While reset is held, the status register and the enable register read zero, the level register reads zero, the threshold register reads 0x80, `irq` is low and `txEmpty` is high.
- R2: A write to address 4 appends a word to the outbound FIFO. `txPopData` shows the oldest word, and each `txPopEn` cycle on a non-empty FIFO removes that word, so words leave in the order they were written. `txEmpty` is high when the FIFO holds no word.
- R3: Address 3 reads the inbound occupancy (0..8) in bits [3:0] and the outbound occupancy (0..8) in bits [7:4], with zeros elsewhere.
- R4: A write to address 4 while the outbound FIFO holds 8 words is discarded. A read of address 5 while the inbound FIFO is empty returns zero and leaves the occupancy unchanged.
- R5: A `rxPushEn` cycle stores `rxPushData` in the inbound FIFO. A read of address 5 returns the oldest word and removes it. A push while 8 words are held is dropped, and it sets status bit 5 (inbound overflow). `rxFull` is high at 8 words.
- R6: A `txPopEn` cycle while the outbound FIFO is empty sets status bit 4 (outbound underflow).
- R7: Address 0 reads the status flags in bits [5:0], with bits [31:6] zero. `evtPending` sets bit 0 and `evtDone` sets bit 1, and each flag stays set after its event ends.
- R8: Writing address 0 clears each status flag whose data bit is 1. If a set condition occurs in the same cycle as the clear, the flag stays set.
- R9: Address 2 holds the outbound trigger level in bits [7:4] and the inbound trigger level in bits [3:0]. Status bit 2 is set one cycle after any cycle in which outbound occupancy is at or below its level. Status bit 3 is set one cycle after any cycle in which inbound occupancy is nonzero and at or above its level.
- R10: Address 1 holds enables: bit 0 for done, bit 1 for outbound threshold, bit 2 for inbound threshold, bit 3 for underflow and bit 4 for overflow. `irq` is the OR of each enabled flag. Flags latch while their enable is clear, and enabling a flag that is already set raises `irq` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops on address 5) |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid in the same cycle as the address |
| txPopEn | input | 1 | Shift engine takes the oldest outbound word |
| txPopData | output | 32 | Oldest outbound word, zero when empty |
| txEmpty | output | 1 | Outbound FIFO holds no word |
| rxPushEn | input | 1 | Shift engine delivers an inbound word |
| rxPushData | input | 32 | Inbound word |
| rxFull | output | 1 | Inbound FIFO holds 8 words |
| evtPending | input | 1 | Transfer-pending event |
| evtDone | input | 1 | Transfer-complete event |
| irq | output | 1 | Combined interrupt |

## Verification
The clear-by-write path and the flag-set paths can act in the same cycle. The bench provokes this by pulsing `evtDone` and `evtPending` in the same cycle as a write of ones to the status register, and then expects both flags still set. It also writes a clear while the outbound occupancy meets its trigger level, and expects bit 2 to survive; with the occupancy above the level, the same clear must leave the bit at zero.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef enum logic [2:0] {
    ADR_STATUS = 3'd0,
    ADR_IRQEN  = 3'd1,
    ADR_THRESH = 3'd2,
    ADR_LEVEL  = 3'd3,
    ADR_TXDATA = 3'd4,
    ADR_RXDATA = 3'd5
  } regAddr_e;

  localparam int STS_W    = 6;
  localparam int STS_PEND = 0;
  localparam int STS_DONE = 1;
  localparam int STS_TXTH = 2;
  localparam int STS_RXTH = 3;
  localparam int STS_TXUF = 4;
  localparam int STS_RXOF = 5;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } fifoStb_t;
endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cntQ;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cntQ  <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   cntQ <= cntQ + 1'b1;
        2'b01:   cntQ <= cntQ - 1'b1;
        default: cntQ <= cntQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  assign head  = mem[rdPtr];
  assign count = cntQ;
endmodule

// File: rtl/spi_fe_datapath.sv
module spi_fe_datapath
  import spi_fe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [DATA_W-1:0] txWrData,
  input  logic [DATA_W-1:0] rxWrData,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);
  logic [DATA_W-1:0] txRaw, rxRaw;

  spi_fe_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) txFifo_i (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pop(stb.txPop),
    .wrData(txWrData), .head(txRaw), .count(txCount)
  );

  spi_fe_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) rxFifo_i (
    .clk(clk), .rstN(rstN), .push(stb.rxPush), .pop(stb.rxPop),
    .wrData(rxWrData), .head(rxRaw), .count(rxCount)
  );

  assign txHead = (txCount == '0) ? '0 : txRaw;
  assign rxHead = (rxCount == '0) ? '0 : rxRaw;
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
  import spi_fe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [2:0]         regAddr,
  input  logic [2*CNT_W-1:0] regWrLow,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               txPopEn,
  input  logic               rxPushEn,
  input  logic               evtPending,
  input  logic               evtDone,
  input  logic [CNT_W-1:0]   txCount,
  input  logic [CNT_W-1:0]   rxCount,
  input  logic [DATA_W-1:0]  rxHead,
  output fifoStb_t           stb,
  output logic [STS_W-1:0]   statusOut,
  output logic               irq
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  regAddr_e addrE;
  logic txFull, txEmptyL, rxFull, rxEmptyL;
  logic wrStatus;
  logic [STS_W-1:0] statusQ, stsSet, stsClr;
  logic [STS_W-2:0] irqEnQ;
  logic [CNT_W-1:0] txThrQ, rxThrQ;

  assign addrE    = regAddr_e'(regAddr);
  assign txFull   = (txCount == FULL_C);
  assign txEmptyL = (txCount == '0);
  assign rxFull   = (rxCount == FULL_C);
  assign rxEmptyL = (rxCount == '0);

  always_comb begin
    stb.txPush = regWrEn && (addrE == ADR_TXDATA) && !txFull;
    stb.txPop  = txPopEn && !txEmptyL;
    stb.rxPush = rxPushEn && !rxFull;
    stb.rxPop  = regRdEn && (addrE == ADR_RXDATA) && !rxEmptyL;
  end

  assign wrStatus = regWrEn && (addrE == ADR_STATUS);
  assign stsClr   = wrStatus ? regWrLow[STS_W-1:0] : '0;

  always_comb begin
    stsSet           = '0;
    stsSet[STS_PEND] = evtPending;
    stsSet[STS_DONE] = evtDone;
    stsSet[STS_TXTH] = (txCount <= txThrQ);
    stsSet[STS_RXTH] = !rxEmptyL && (rxCount >= rxThrQ);
    stsSet[STS_TXUF] = txPopEn && txEmptyL;
    stsSet[STS_RXOF] = rxPushEn && rxFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      irqEnQ  <= '0;
      txThrQ  <= FULL_C;
      rxThrQ  <= '0;
    end else begin
      statusQ <= (statusQ & ~stsClr) | stsSet;
      if (regWrEn && addrE == ADR_IRQEN) irqEnQ <= regWrLow[STS_W-2:0];
      if (regWrEn && addrE == ADR_THRESH) begin
        rxThrQ <= regWrLow[CNT_W-1:0];
        txThrQ <= regWrLow[2*CNT_W-1:CNT_W];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (addrE)
      ADR_STATUS: regRdData[STS_W-1:0] = statusQ;
      ADR_IRQEN:  regRdData[STS_W-2:0] = irqEnQ;
      ADR_THRESH: begin
        regRdData[CNT_W-1:0]       = rxThrQ;
        regRdData[2*CNT_W-1:CNT_W] = txThrQ;
      end
      ADR_LEVEL: begin
        regRdData[CNT_W-1:0]       = rxCount;
        regRdData[2*CNT_W-1:CNT_W] = txCount;
      end
      ADR_RXDATA: regRdData = rxHead;
      default:    regRdData = '0;
    endcase
  end

  assign statusOut = statusQ;
  assign irq       = |(statusQ[STS_W-1:1] & irqEnQ);
endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
  import spi_fe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txPopEn,
  output logic [DATA_W-1:0] txPopData,
  output logic              txEmpty,
  input  logic              rxPushEn,
  input  logic [DATA_W-1:0] rxPushData,
  output logic              rxFull,
  input  logic              evtPending,
  input  logic              evtDone,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoStb_t         stb;
  logic [CNT_W-1:0] txCount, rxCount;
  logic [DATA_W-1:0] rxHead;
  logic [STS_W-1:0] statusVec;

  spi_fe_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrLow(regWrData[2*CNT_W-1:0]),
    .regRdData(regRdData), .txPopEn(txPopEn), .rxPushEn(rxPushEn),
    .evtPending(evtPending), .evtDone(evtDone), .txCount(txCount),
    .rxCount(rxCount), .rxHead(rxHead), .stb(stb),
    .statusOut(statusVec), .irq(irq)
  );

  spi_fe_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .txWrData(regWrData),
    .rxWrData(rxPushData), .txHead(txPopData), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount)
  );

  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount == CNT_W'(DEPTH));
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [2:0]        regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              txPopEn,
  input logic              rxPushEn,
  input logic              evtDone,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount,
  input logic [5:0]        statusVec,
  input logic              irq
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CNT_W'(DEPTH)) && (rxCount <= CNT_W'(DEPTH))); // R3

  AST_TX_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!txPopEn && !(regWrEn && regAddr == 3'd4)) |=> $stable(txCount)); // R2

  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == CNT_W'(DEPTH) && regWrEn && regAddr == 3'd4 && !txPopEn)
    |=> (txCount == CNT_W'(DEPTH))); // R4

  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0 && regRdEn && regAddr == 3'd5) |-> (regRdData == '0)); // R4

  AST_RX_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rxPushEn && rxCount == CNT_W'(DEPTH)) |=> statusVec[5]); // R5

  AST_TX_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (txPopEn && txCount == '0) |=> statusVec[4]); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evtDone |=> statusVec[1]); // R8

  AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec[5:1] == 5'd0) |-> !irq); // R10
endmodule

bind spi_fe_top spi_fe_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regRdData(regRdData), .txPopEn(txPopEn),
  .rxPushEn(rxPushEn), .evtDone(evtDone), .txCount(txCount),
  .rxCount(rxCount), .statusVec(statusVec), .irq(irq)
);

// File: tb/spi_fe_top_tb.sv
module spi_fe_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        txPopEn = 1'b0;
  logic [31:0] txPopData;
  logic        txEmpty;
  logic        rxPushEn = 1'b0;
  logic [31:0] rxPushData = '0;
  logic        rxFull;
  logic        evtPending = 1'b0, evtDone = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  spi_fe_top dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txPopEn(txPopEn), .txPopData(txPopData), .txEmpty(txEmpty),
    .rxPushEn(rxPushEn), .rxPushData(rxPushData), .rxFull(rxFull),
    .evtPending(evtPending), .evtDone(evtDone), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    tick();
    regRdEn = 1'b0;
  endtask

  task automatic popTx();
    txPopEn = 1'b1;
    tick();
    txPopEn = 1'b0;
  endtask

  task automatic pushRx(input logic [31:0] d);
    rxPushData = d; rxPushEn = 1'b1;
    tick();
    rxPushEn = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    regAddr = 3'd0; #1 check("R1 status", regRdData, 32'h0);
    regAddr = 3'd1; #1 check("R1 irqen", regRdData, 32'h0);
    regAddr = 3'd2; #1 check("R1 thresh", regRdData, 32'h80);
    regAddr = 3'd3; #1 check("R1 level", regRdData, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 txEmpty", {31'b0, txEmpty}, 32'h1);
    @(negedge clk); rstN = 1'b1;
    tick();
    regRead(3'd3, d);
    check("R1 level after release", d, 32'h0);
  endtask

  task automatic testTxOrder();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) regWrite(3'd4, 32'h1100_0000 + i);
    regRead(3'd3, d);
    check("R3 level tx=3", d, 32'h30);
    check("R2 head word0", txPopData, 32'h1100_0000);
    popTx();
    check("R2 head word1", txPopData, 32'h1100_0001);
    regRead(3'd3, d);
    check("R3 level tx=2", d, 32'h20);
    popTx(); popTx();
    check("R2 txEmpty", {31'b0, txEmpty}, 32'h1);
    check("R2 head empty zero", txPopData, 32'h0);
  endtask

  task automatic testTxFull();
    logic [31:0] d;
    for (int i = 0; i < 9; i++) regWrite(3'd4, 32'hA500_0000 + i);
    regRead(3'd3, d);
    check("R4 level stays 8", d, 32'h80);
    for (int i = 0; i < 8; i++) begin
      check("R4 pop order after drop", txPopData, 32'hA500_0000 + i);
      popTx();
    end
    check("R4 dropped word absent", {31'b0, txEmpty}, 32'h1);
  endtask

  task automatic testUnderflow();
    logic [31:0] d;
    regWrite(3'd0, 32'h3F);
    popTx();
    regRead(3'd0, d);
    check("R6 underflow bit", {31'b0, d[4]}, 32'h1);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    regWrite(3'd1, 32'h08);
    check("R10 enable raises irq", {31'b0, irq}, 32'h1);
    regWrite(3'd0, 32'h10);
    regRead(3'd0, d);
    check("R8 underflow cleared", {31'b0, d[4]}, 32'h0);
    check("R10 irq low after clear", {31'b0, irq}, 32'h0);
    regWrite(3'd1, 32'h0);
  endtask

  task automatic testRx();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) pushRx(32'hB000_0000 + i);
    regRead(3'd3, d);
    check("R3 level rx=3", d, 32'h03);
    for (int i = 0; i < 3; i++) begin
      regRead(3'd5, d);
      check("R5 rx read order", d, 32'hB000_0000 + i);
    end
    regRead(3'd5, d);
    check("R4 empty rx read zero", d, 32'h0);
    regRead(3'd3, d);
    check("R4 empty read keeps level", d, 32'h0);
    regWrite(3'd0, 32'h3F);
    for (int i = 0; i < 9; i++) pushRx(32'hC000_0000 + i);
    check("R5 rxFull", {31'b0, rxFull}, 32'h1);
    regRead(3'd0, d);
    check("R5 overflow bit", {31'b0, d[5]}, 32'h1);
    for (int i = 0; i < 8; i++) begin
      regRead(3'd5, d);
      check("R5 rx order after drop", d, 32'hC000_0000 + i);
    end
    regWrite(3'd0, 32'h3F);
  endtask

  task automatic testThreshold();
    logic [31:0] d;
    regWrite(3'd2, 32'h23);
    regRead(3'd2, d);
    check("R9 thresh readback", d, 32'h23);
    for (int i = 0; i < 5; i++) regWrite(3'd4, 32'hD000_0000 + i);
    tick();
    regWrite(3'd0, 32'h3F);
    regRead(3'd0, d);
    check("R9 tx above level clears", d[3:0], 4'h0);
    pushRx(32'h1); pushRx(32'h2);
    tick();
    regRead(3'd0, d);
    check("R9 rx below level", {31'b0, d[3]}, 32'h0);
    pushRx(32'h3);
    tick();
    regRead(3'd0, d);
    check("R9 rx at level", {31'b0, d[3]}, 32'h1);
    popTx(); popTx(); popTx();
    tick();
    regRead(3'd0, d);
    check("R9 tx at level", {31'b0, d[2]}, 32'h1);
    regWrite(3'd0, 32'h04);
    regRead(3'd0, d);
    check("R8 clear loses to held level", {31'b0, d[2]}, 32'h1);
    for (int i = 0; i < 3; i++) regRead(3'd5, d);
    popTx(); popTx();
    regWrite(3'd2, 32'h80);
    regWrite(3'd0, 32'h3F);
  endtask

  task automatic testCollision();
    logic [31:0] d;
    evtDone = 1'b1; evtPending = 1'b1;
    regWrite(3'd0, 32'h03);
    evtDone = 1'b0; evtPending = 1'b0;
    regRead(3'd0, d);
    check("R8 set wins over clear", {30'b0, d[1:0]}, 32'h3);
    check("R7 upper bits zero", {6'b0, d[31:6]}, 32'h0);
    regWrite(3'd0, 32'h03);
    regRead(3'd0, d);
    check("R7 events cleared", {30'b0, d[1:0]}, 32'h0);
  endtask

  task automatic testIrqMask();
    logic [31:0] d;
    evtDone = 1'b1; tick(); evtDone = 1'b0;
    tick();
    regRead(3'd0, d);
    check("R7 done sticky", {31'b0, d[1]}, 32'h1);
    check("R10 irq off when disabled", {31'b0, irq}, 32'h0);
    regWrite(3'd1, 32'h01);
    check("R10 done enable", {31'b0, irq}, 32'h1);
    regWrite(3'd0, 32'h02);
    check("R10 irq drops on clear", {31'b0, irq}, 32'h0);
    regWrite(3'd1, 32'h02);
    check("R10 tx threshold enable", {31'b0, irq}, 32'h1);
    regWrite(3'd1, 32'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testTxOrder();
    testTxFull();
    testUnderflow();
    testRx();
    testThreshold();
    testCollision();
    testIrqMask();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule